// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a radix page table that has four levels and lives in memory. A walk begins at the table whose frame number sits on the root input. At each level the block takes a 9-bit slice of the virtual address, reads one 64-bit entry through a request/response memory port, and then does one of three things: it descends to the next table, it stops at a leaf, or it stops with a fault. Entries at the second and third levels may be leaves that map 1 GB and 2 MB regions. At the fourth level every entry is a 4 KB leaf.

Each request carries an access kind and a privilege flag. When a leaf is found, the block checks permissions. Writable and user rights are gathered across every level of the walk, and no-execute is taken from the leaf. If the access is allowed and the leaf's accessed or dirty flag needs setting, the block writes the entry back before it replies. The result is one of two things. The first is a physical address with the page size and the effective rights. The second is a fault with a cause code and the virtual address that caused it. Only one walk is in flight at a time.

The controller is a state machine with six states. ST_IDLE accepts a request. ST_FETCH issues an entry read and ST_FWAIT waits for its data. ST_UPDATE issues the flag write-back and ST_UWAIT waits for its acknowledge. ST_REPLY holds the result until it is taken. The transitions are:
- ST_IDLE to ST_FETCH on an accepted request.
- ST_FETCH to ST_FWAIT when the memory takes the read.
- ST_FWAIT back to ST_FETCH on a pointer entry.
- ST_FWAIT to ST_UPDATE on an allowed leaf whose flags need changing.
- ST_FWAIT to ST_REPLY on a fault, or on a leaf that needs no change.
- ST_UPDATE to ST_UWAIT when the write is taken.
- ST_UWAIT to ST_REPLY on the write acknowledge.
- ST_REPLY to ST_IDLE when the result is taken.

Top module: `ptw_walker`

## Requirements
- R1: The entry read at level k (k = 0 is the first level) goes to {table frame, index_k, 3'b000}. index_0..index_3 are virtual-address bits 47:39, 38:30, 29:21 and 20:12. The level-0 table frame is `root_ppn_i`. The table frame at every later level is bits 51:12 of the entry read one level above.
- R2: An entry is valid when bit 0 is 1. A walk where every entry is valid and no size flag (bit 7) ends it early makes exactly four reads. It returns `res_pa_o` = {leaf bits 51:12, va[11:0]} with `res_size_o` = 0.
- R3: A valid level-1 entry with bit 7 set is a 1 GB leaf. The walk ends after two reads with `res_pa_o` = {entry bits 51:30, va[29:0]} and `res_size_o` = 2.
- R4: A valid level-2 entry with bit 7 set is a 2 MB leaf. The walk ends after three reads with `res_pa_o` = {entry bits 51:21, va[20:0]} and `res_size_o` = 1. Bit 7 is ignored at levels 0 and 3.
- R5: An entry with bit 0 clear at any level ends the walk at once. The result has `res_fault_o` = 1, `res_cause_o` = 1 and `res_va_o` equal to the request address. No further read and no write follow.
- R6: `req_acc_i` is encoded as 0 = read, 1 = write, 2 = instruction fetch. An allowed leaf yields a protection fault (`res_cause_o` = 2) with no write-back in any of these cases: a write where the effective writable right is 0, a user access (`req_user_i` = 1) where the effective user right is 0, or a fetch where leaf bit 63 (no-execute) is 1. A supervisor access is never refused for user rights.
- R7: The effective writable right (bit 1) and user right (bit 2) are the AND of those bits over every entry the walk read, including the leaf. They are reported on `res_write_ok_o` and `res_user_ok_o` when the walk succeeds.
- R8: After a successful walk, the entry is written back to the leaf's address in two cases: accessed (bit 5) is 0, or the access is a write and dirty (bit 6) is 0. The written value is the leaf with bit 5 set, and with bit 6 also set on a write. If neither case holds, no write is issued.
- R9: `req_ready_o` is high only when no walk is in progress. It drops after a request is accepted and stays low until the result has been taken. While `res_ready_i` is low, the result outputs hold steady with `res_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| root_ppn_i | input | 40 | Frame number of the first-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request taken when valid |
| req_va_i | input | 48 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | 1 for a user-mode access |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_we_o | output | 1 | 1 for an entry write-back |
| mem_req_addr_o | output | 52 | Physical address of the entry |
| mem_req_wdata_o | output | 64 | Entry value for a write-back |
| mem_rsp_valid_i | input | 1 | One pulse per request: read data or write acknowledge |
| mem_rsp_data_i | input | 64 | Entry read data |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result taken |
| res_fault_o | output | 1 | Walk ended in a fault |
| res_cause_o | output | 2 | 0 none, 1 not present, 2 protection |
| res_va_o | output | 48 | Virtual address of the walk (faulting address on a fault) |
| res_pa_o | output | 52 | Translated physical address |
| res_size_o | output | 2 | 0 for 4 KB, 1 for 2 MB, 2 for 1 GB |
| res_write_ok_o | output | 1 | Effective writable right |
| res_user_ok_o | output | 1 | Effective user right |
| res_noexec_o | output | 1 | No-execute flag of the leaf |

## Verification
The assertions take three things for granted about the environment. First, the memory raises exactly one response pulse for every request it has taken, and never while no request is outstanding. Second, requests hold steady while they are being offered. Third, `req_acc_i` uses only the three defined codes. The stimulus respects all three. A responder in the bench answers each accepted request on the following cycle, and randomizes `mem_req_ready_i` only between clock edges. Request fields are driven only while the walker is idle, and access kinds are drawn from 0 to 2. The random entry tables keep most entries valid, so that walks regularly reach all three leaf sizes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTE_W     = 64;
    localparam int BIT_VALID = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_USR   = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;
    localparam int BIT_HUGE  = 7;
    localparam int BIT_NOEX  = 63;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PROT   = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_UPDATE,
        ST_UWAIT,
        ST_REPLY
    } walk_st_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int FRM_W = PA_W - OFF_W
) (
    input  logic [VA_W-1:0]  va_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [FRM_W-1:0] frame_i,
    output logic [PA_W-1:0]  entry_addr_o
);

    localparam int ENT_SHIFT = $clog2(ptw_pkg::PTE_W / 8);

    logic [IDX_W-1:0] slice_arr [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    // One virtual-address slice per level; level 0 takes the highest bits.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice_arr[g] = va_i[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    assign idx_sel      = slice_arr[level_i];
    assign entry_addr_o = {frame_i, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << ENT_SHIFT);

    logic unused_offset;
    assign unused_offset = ^va_i[OFF_W-1:0];

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int LEVELS  = 4,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12,
    parameter int HUGE_LO = 1,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [VA_W-1:0]  va_i,
    input  acc_kind_e        acc_i,
    input  logic             user_i,
    input  logic             cum_wr_i,
    input  logic             cum_usr_i,
    output logic             present_o,
    output logic             leaf_o,
    output logic             prot_o,
    output logic             upd_o,
    output logic [PTE_W-1:0] upd_pte_o,
    output logic [PA_W-1:0]  pa_o,
    output logic [LVL_W-1:0] size_o,
    output logic             eff_wr_o,
    output logic             eff_usr_o
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0] HUGE_LVL = LVL_W'(HUGE_LO);

    logic              huge_ok;
    logic              is_write;
    logic              is_fetch;
    int unsigned       keep_bits;
    logic [PA_W-1:0]   keep_mask;
    logic [PA_W-1:0]   frame_addr;

    assign present_o = pte_i[BIT_VALID];
    assign eff_wr_o  = cum_wr_i  & pte_i[BIT_WR];
    assign eff_usr_o = cum_usr_i & pte_i[BIT_USR];
    assign is_write  = (acc_i == ACC_WRITE);
    assign is_fetch  = (acc_i == ACC_FETCH);

    // The size flag only means "leaf" on levels that can map a large region.
    assign huge_ok = (level_i >= HUGE_LVL) && (level_i < LAST_LVL);
    assign leaf_o  = present_o && ((level_i == LAST_LVL) || (huge_ok && pte_i[BIT_HUGE]));

    always_comb begin
        prot_o = 1'b0;
        if (leaf_o) begin
            if (is_write && !eff_wr_o)      prot_o = 1'b1;
            if (user_i && !eff_usr_o)       prot_o = 1'b1;
            if (is_fetch && pte_i[BIT_NOEX]) prot_o = 1'b1;
        end
    end

    always_comb begin
        upd_o     = !pte_i[BIT_ACC] || (is_write && !pte_i[BIT_DIRTY]);
        upd_pte_o = pte_i;
        upd_pte_o[BIT_ACC] = 1'b1;
        if (is_write) upd_pte_o[BIT_DIRTY] = 1'b1;
    end

    // A leaf higher in the tree keeps more virtual bits as the page offset.
    always_comb begin
        keep_bits  = OFF_W + IDX_W * (LEVELS - 1 - int'(level_i));
        keep_mask  = ~({PA_W{1'b1}} << keep_bits);
        frame_addr = {pte_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        pa_o       = (frame_addr & ~keep_mask) | (PA_W'(va_i) & keep_mask);
        size_o     = LAST_LVL - level_i;
    end

    logic unused_fields;
    assign unused_fields = ^{pte_i[62:PA_W], pte_i[11:8], pte_i[4:3]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int PA_W    = 52,
    parameter int LEVELS  = 4,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12,
    parameter int HUGE_LO = 1,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int FRM_W  = PA_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FRM_W-1:0]  root_ppn_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_va_i,
    input  logic [1:0]        req_acc_i,
    input  logic              req_user_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_we_o,
    output logic [PA_W-1:0]   mem_req_addr_o,
    output logic [PTE_W-1:0]  mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [PTE_W-1:0]  mem_rsp_data_i,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              res_fault_o,
    output logic [1:0]        res_cause_o,
    output logic [VA_W-1:0]   res_va_o,
    output logic [PA_W-1:0]   res_pa_o,
    output logic [LVL_W-1:0]  res_size_o,
    output logic              res_write_ok_o,
    output logic              res_user_ok_o,
    output logic              res_noexec_o
);

    walk_st_e          state_q, state_d;
    logic [LVL_W-1:0]  level_q;
    logic [FRM_W-1:0]  frame_q;
    logic [VA_W-1:0]   va_q;
    acc_kind_e         acc_q;
    logic              user_q;
    logic              cum_wr_q, cum_usr_q;
    logic [PTE_W-1:0]  wb_data_q;

    logic              fault_q;
    cause_e            cause_q;
    logic [PA_W-1:0]   pa_q;
    logic [LVL_W-1:0]  size_q;
    logic              wr_ok_q, usr_ok_q, noex_q;

    logic [PA_W-1:0]   entry_addr;
    logic              ev_present, ev_leaf, ev_prot, ev_upd;
    logic [PTE_W-1:0]  ev_upd_pte;
    logic [PA_W-1:0]   ev_pa;
    logic [LVL_W-1:0]  ev_size;
    logic              ev_wr, ev_usr;

    logic              accept;
    logic              rsp_seen;

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign rsp_seen = (state_q == ST_FWAIT) && mem_rsp_valid_i;

    ptw_index_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_index (
        .va_i         (va_q),
        .level_i      (level_q),
        .frame_i      (frame_q),
        .entry_addr_o (entry_addr)
    );

    ptw_leaf_eval #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .HUGE_LO(HUGE_LO)
    ) u_leaf (
        .pte_i     (mem_rsp_data_i),
        .level_i   (level_q),
        .va_i      (va_q),
        .acc_i     (acc_q),
        .user_i    (user_q),
        .cum_wr_i  (cum_wr_q),
        .cum_usr_i (cum_usr_q),
        .present_o (ev_present),
        .leaf_o    (ev_leaf),
        .prot_o    (ev_prot),
        .upd_o     (ev_upd),
        .upd_pte_o (ev_upd_pte),
        .pa_o      (ev_pa),
        .size_o    (ev_size),
        .eff_wr_o  (ev_wr),
        .eff_usr_o (ev_usr)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_FETCH;
            ST_FETCH:  if (mem_req_ready_i) state_d = ST_FWAIT;
            ST_FWAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!ev_present || ev_prot) state_d = ST_REPLY;
                    else if (!ev_leaf)          state_d = ST_FETCH;
                    else if (ev_upd)            state_d = ST_UPDATE;
                    else                        state_d = ST_REPLY;
                end
            end
            ST_UPDATE: if (mem_req_ready_i) state_d = ST_UWAIT;
            ST_UWAIT:  if (mem_rsp_valid_i) state_d = ST_REPLY;
            ST_REPLY:  if (res_ready_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready_o     = (state_q == ST_IDLE);
        mem_req_valid_o = (state_q == ST_FETCH) || (state_q == ST_UPDATE);
        mem_req_we_o    = (state_q == ST_UPDATE);
        mem_req_addr_o  = entry_addr;
        mem_req_wdata_o = wb_data_q;
        res_valid_o     = (state_q == ST_REPLY);
        res_fault_o     = fault_q;
        res_cause_o     = cause_q;
        res_va_o        = va_q;
        res_pa_o        = pa_q;
        res_size_o      = size_q;
        res_write_ok_o  = wr_ok_q;
        res_user_ok_o   = usr_ok_q;
        res_noexec_o    = noex_q;
    end

    // Walk context: request fields, current level and table frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_q   <= '0;
            frame_q   <= '0;
            va_q      <= '0;
            acc_q     <= ACC_READ;
            user_q    <= 1'b0;
            cum_wr_q  <= 1'b1;
            cum_usr_q <= 1'b1;
        end else if (accept) begin
            level_q   <= '0;
            frame_q   <= root_ppn_i;
            va_q      <= req_va_i;
            acc_q     <= acc_kind_e'(req_acc_i);
            user_q    <= req_user_i;
            cum_wr_q  <= 1'b1;
            cum_usr_q <= 1'b1;
        end else if (rsp_seen && ev_present && !ev_leaf) begin
            level_q   <= level_q + LVL_W'(1);
            frame_q   <= mem_rsp_data_i[PA_W-1:OFF_W];
            cum_wr_q  <= ev_wr;
            cum_usr_q <= ev_usr;
        end
    end

    // Result and write-back registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fault_q   <= 1'b0;
            cause_q   <= CAUSE_NONE;
            pa_q      <= '0;
            size_q    <= '0;
            wr_ok_q   <= 1'b0;
            usr_ok_q  <= 1'b0;
            noex_q    <= 1'b0;
            wb_data_q <= '0;
        end else if (rsp_seen) begin
            if (!ev_present) begin
                fault_q <= 1'b1;
                cause_q <= CAUSE_ABSENT;
                pa_q    <= '0;
            end else if (ev_leaf) begin
                fault_q   <= ev_prot;
                cause_q   <= ev_prot ? CAUSE_PROT : CAUSE_NONE;
                pa_q      <= ev_prot ? '0 : ev_pa;
                size_q    <= ev_size;
                wr_ok_q   <= ev_wr;
                usr_ok_q  <= ev_usr;
                noex_q    <= mem_rsp_data_i[BIT_NOEX];
                wb_data_q <= ev_upd_pte;
            end
        end
    end

    // Assertions
    p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
                                                && $stable(mem_req_we_o));

    p_entry_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

    p_wb_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[BIT_ACC] && mem_req_wdata_o[BIT_VALID]
                                            && (acc_q != ACC_WRITE || mem_req_wdata_o[BIT_DIRTY]));

    p_cause_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> (res_fault_o == (res_cause_o != 2'd0)));

    p_one_walk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && req_ready_o |=> !req_ready_o);

    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_pa_o) && $stable(res_fault_o)
                                        && $stable(res_cause_o));

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] root_ppn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready_o;
    logic [47:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        mem_req_valid_o;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we_o;
    logic [51:0] mem_req_addr_o;
    logic [63:0] mem_req_wdata_o;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid_o;
    logic        res_ready = 1'b0;
    logic        res_fault_o;
    logic [1:0]  res_cause_o;
    logic [47:0] res_va_o;
    logic [51:0] res_pa_o;
    logic [1:0]  res_size_o;
    logic        res_write_ok_o, res_user_ok_o, res_noexec_o;

    always #2 clk = ~clk;

    ptw_walker uut (
        .clk_i(clk), .rst_ni(rst_n), .root_ppn_i(root_ppn),
        .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_va_i(req_va),
        .req_acc_i(req_acc), .req_user_i(req_user),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready),
        .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .res_valid_o(res_valid_o), .res_ready_i(res_ready),
        .res_fault_o(res_fault_o), .res_cause_o(res_cause_o), .res_va_o(res_va_o),
        .res_pa_o(res_pa_o), .res_size_o(res_size_o), .res_write_ok_o(res_write_ok_o),
        .res_user_ok_o(res_user_ok_o), .res_noexec_o(res_noexec_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Memory model: four entries, one per level, returned in read order
    logic [63:0] tbl [4];
    logic [51:0] rd_addr [8];
    int          rd_n = 0;
    int          wr_n = 0;
    logic [51:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    bit          rsp_pend = 0;
    logic [63:0] rsp_next = '0;

    // Expected results
    bit          e_fault;
    logic [1:0]  e_cause;
    logic [51:0] e_pa;
    logic [1:0]  e_size;
    int          e_reads;
    logic [51:0] e_addr [4];
    bit          e_wb;
    logic [63:0] e_wdata;
    bit          e_wok, e_uok;

    always @(posedge clk) begin
        cycles++;
        if (rst_n && mem_req_valid_o && mem_req_ready) begin
            if (mem_req_we_o) begin
                wr_addr = mem_req_addr_o;
                wr_data = mem_req_wdata_o;
                wr_n++;
                rsp_next = '0;
            end else begin
                if (rd_n < 8) rd_addr[rd_n] = mem_req_addr_o;
                rsp_next = (rd_n < 4) ? tbl[rd_n] : 64'h0;
                rd_n++;
            end
            rsp_pend = 1;
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = rsp_pend;
        mem_rsp_data  = rsp_next;
        rsp_pend      = 0;
        mem_req_ready = ($urandom % 4) != 0;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [39:0] fr, input logic [7:0] fl, input bit nx);
        return {nx, 11'h0, fr, 4'h0, fl};
    endfunction

    // Reference model built from the requirements
    task automatic predict(input logic [47:0] va, input logic [1:0] acc, input bit usr,
                           input logic [39:0] root);
        logic [39:0] base;
        logic [8:0]  idx;
        bit          cw, cu, leaf;
        logic [63:0] p;
        base = root; cw = 1; cu = 1;
        e_fault = 0; e_cause = 0; e_pa = '0; e_size = 0; e_wb = 0; e_wdata = '0;
        e_reads = 0; e_wok = 0; e_uok = 0;
        for (int lv = 0; lv < 4; lv++) begin
            case (lv)
                0: idx = va[47:39];
                1: idx = va[38:30];
                2: idx = va[29:21];
                default: idx = va[20:12];
            endcase
            e_addr[lv] = {base, idx, 3'b000};
            p = tbl[lv];
            e_reads = lv + 1;
            if (!p[0]) begin
                e_fault = 1; e_cause = 2'd1;
                return;
            end
            cw = cw & p[1];
            cu = cu & p[2];
            leaf = (lv == 3) || ((lv == 1 || lv == 2) && p[7]);
            if (!leaf) begin
                base = p[51:12];
            end else begin
                if ((acc == 2'd1 && !cw) || (usr && !cu) || (acc == 2'd2 && p[63])) begin
                    e_fault = 1; e_cause = 2'd2;
                    return;
                end
                case (lv)
                    1: begin e_pa = {p[51:30], va[29:0]}; e_size = 2; end
                    2: begin e_pa = {p[51:21], va[20:0]}; e_size = 1; end
                    default: begin e_pa = {p[51:12], va[11:0]}; e_size = 0; end
                endcase
                e_wok = cw; e_uok = cu;
                e_wb = !p[5] || (acc == 2'd1 && !p[6]);
                e_wdata = p | 64'h20 | ((acc == 2'd1) ? 64'h40 : 64'h0);
                return;
            end
        end
    endtask

    task automatic run_walk(input string tag, input logic [47:0] va, input logic [1:0] acc,
                            input bit usr, input logic [39:0] root);
        int n;
        logic [51:0] held_pa;
        predict(va, acc, usr, root);
        @(negedge clk);
        rd_n = 0; wr_n = 0;
        root_ppn = root; req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!res_valid_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(tag, "result arrives", {63'h0, res_valid_o}, 64'h1);
        chk(tag, "fault", {63'h0, res_fault_o}, {63'h0, e_fault});
        chk(tag, "cause", {62'h0, res_cause_o}, {62'h0, e_cause});
        if (e_fault) begin
            chk("R5", "faulting va", {16'h0, res_va_o}, {16'h0, va});
        end else begin
            chk(tag, "pa", {12'h0, res_pa_o}, {12'h0, e_pa});
            chk(tag, "size", {62'h0, res_size_o}, {62'h0, e_size});
            chk("R7", "write right", {63'h0, res_write_ok_o}, {63'h0, e_wok});
            chk("R7", "user right", {63'h0, res_user_ok_o}, {63'h0, e_uok});
        end
        chk("R1", "read count", 64'(rd_n), 64'(e_reads));
        for (int k = 0; k < 4; k++)
            if (k < e_reads && k < rd_n)
                chk("R1", "entry address", {12'h0, rd_addr[k]}, {12'h0, e_addr[k]});
        chk("R8", "write count", 64'(wr_n), e_wb ? 64'd1 : 64'd0);
        if (e_wb && wr_n == 1) begin
            chk("R8", "write address", {12'h0, wr_addr}, {12'h0, e_addr[e_reads-1]});
            chk("R8", "write data", wr_data, e_wdata);
        end
        chk("R9", "ready low while result pending", {63'h0, req_ready_o}, 64'h0);
        held_pa = res_pa_o;
        repeat (2) @(negedge clk);
        chk("R9", "result held", {11'h0, res_valid_o, res_pa_o}, {11'h0, 1'b1, held_pa});
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R9", "ready after handover", {63'h0, req_ready_o}, 64'h1);
    endtask

    localparam logic [7:0] FP = 8'h01, FW = 8'h02, FU = 8'h04, FA = 8'h20, FD = 8'h40, FH = 8'h80;

    initial begin
        int seed_dummy;
        logic [7:0] full;
        seed_dummy = $urandom(32'd2024);
        full = FP | FW | FU | FA;
        repeat (3) @(negedge clk);
        chk("R9", "reset ready", {63'h0, req_ready_o}, 64'h1);
        chk("R1", "reset mem idle", {63'h0, mem_req_valid_o}, 64'h0);
        chk("R9", "reset result idle", {63'h0, res_valid_o}, 64'h0);
        rst_n = 1'b1;

        // R2: plain 4 KB read, nothing to update
        tbl[0] = ent(40'h00011, full, 0); tbl[1] = ent(40'h00022, full, 0);
        tbl[2] = ent(40'h00033, full, 0); tbl[3] = ent(40'hABCDE, full | FD, 0);
        run_walk("R2", 48'h7f12_3456_789a, 2'd0, 1, 40'h00123);
        // R8: write with dirty clear
        tbl[3] = ent(40'h12345, full, 0);
        run_walk("R8", 48'h0000_4020_1abc, 2'd1, 0, 40'h00321);
        // R8: read with accessed clear
        tbl[3] = ent(40'h54321, FP | FW | FU, 0);
        run_walk("R8", 48'h8001_0002_3fff, 2'd0, 1, 40'h00aaa);
        // R3: 1 GB leaf, fetch
        tbl[1] = ent(40'hFFFFF, full | FD | FH, 0);
        run_walk("R3", 48'h1234_5678_9abc, 2'd2, 0, 40'h00777);
        // R4: 2 MB leaf, write with flags already set
        tbl[1] = ent(40'h00022, full, 0);
        tbl[2] = ent(40'hFEDCB, full | FD | FH, 0);
        run_walk("R4", 48'h0fed_cba9_8765, 2'd1, 1, 40'h00100);
        // R4: size flag ignored on the last level
        tbl[2] = ent(40'h00033, full, 0);
        tbl[3] = ent(40'h0F0F0, full | FD | FH, 0);
        run_walk("R4", 48'h0000_0000_1234, 2'd0, 0, 40'h00100);
        // R5: not present at level 0 and at level 2
        tbl[0] = ent(40'h00011, FW | FU, 0);
        run_walk("R5", 48'h5555_aaaa_5555, 2'd1, 1, 40'h00200);
        tbl[0] = ent(40'h00011, full, 0); tbl[2] = ent(40'h00033, FW | FU | FA, 0);
        run_walk("R5", 48'h2222_1111_0000, 2'd0, 0, 40'h00200);
        // R6: write to read-only leaf, user to supervisor leaf, fetch from no-execute leaf
        tbl[2] = ent(40'h00033, full, 0);
        tbl[3] = ent(40'h0AAAA, FP | FU | FA, 0);
        run_walk("R6", 48'h0000_1000_0000, 2'd1, 0, 40'h00300);
        tbl[3] = ent(40'h0AAAA, FP | FW | FA, 0);
        run_walk("R6", 48'h0000_1000_0000, 2'd0, 1, 40'h00300);
        tbl[3] = ent(40'h0AAAA, full, 1);
        run_walk("R6", 48'h0000_1000_0000, 2'd2, 0, 40'h00300);
        // R6: supervisor may use a non-user leaf
        tbl[3] = ent(40'h0AAAA, FP | FW | FA, 0);
        run_walk("R6", 48'h0000_1000_0000, 2'd0, 0, 40'h00300);
        // R7: upper level denies writes although the leaf allows them
        tbl[1] = ent(40'h00022, FP | FU | FA, 0);
        tbl[3] = ent(40'h0BBBB, full | FD, 0);
        run_walk("R7", 48'h0000_2000_0000, 2'd1, 0, 40'h00400);
        // R7: upper level denies user access
        tbl[1] = ent(40'h00022, FP | FW | FA, 0);
        run_walk("R7", 48'h0000_2000_0000, 2'd0, 1, 40'h00400);
        run_walk("R7", 48'h0000_2000_0000, 2'd0, 0, 40'h00400);

        // Random walks over all levels, sizes and access kinds
        for (int t = 0; t < 80; t++) begin
            logic [47:0] va;
            logic [1:0]  acc;
            for (int lv = 0; lv < 4; lv++) begin
                logic [63:0] e;
                e = {$urandom, $urandom};
                e[0] = ($urandom % 10) != 0;
                e[1] = ($urandom % 5) != 0;
                e[2] = ($urandom % 5) != 0;
                e[7] = ($urandom % 4) == 0;
                e[63] = ($urandom % 6) == 0;
                tbl[lv] = e;
            end
            va  = {$urandom, $urandom};
            acc = 2'($urandom % 3);
            run_walk("R2", va, acc, 1'($urandom), {$urandom, 8'($urandom)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule